// File: doc/BRIEF.md
# Register-List Frame Entry/Exit Sequencer

This block carries out the prologue and epilogue of a subroutine frame for a processor core that has already decoded the instruction. It works on a twelve-register group, r20 through r31. Each register in the group has one bit in a list mask. A five-bit immediate sizes the local area of the frame in words.

On entry the block saves the selected registers to memory below the stack pointer, one word at a time. It then lowers the stack pointer further by the local area. On exit the order runs the other way. The stack pointer is first raised past the local area. The selected registers are then reloaded from consecutive words in the reverse of the save order. If a register number was given for a jump, the block reads that register last and reports its value as the next program counter.

The core supplies the starting stack pointer together with a one-cycle start pulse. It gives the block access to its register file through a combinational read port and a write-enable port. Memory is reached through a single word-wide request port that uses a ready handshake. The block signals completion with a one-cycle done pulse, and it presents the final stack pointer on `sp_out`.

Top module: `frame_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pc_valid`, `mem_req` and `reg_we` are low and `sp_out` is zero.
- R2: In entry mode (`mode` = 0), mask bit i selects register 20+i. The selected registers are stored in ascending index order. Each store writes the register to address SP-4 with `mem_we` = 1, and SP then becomes that address. As a result, the lower-numbered registers end up at the higher addresses.
- R3: When all entry stores are complete, `sp_out` equals `sp_in` - 4×(number of selected registers) - 4×`frame_imm`.
- R4: In exit mode (`mode` = 1), SP is first set to `sp_in` + 4×`frame_imm`. The selected registers are then loaded in descending index order. Each load reads address SP with `mem_we` = 0, writes the returned word into register 20+i, and then adds 4 to SP. The final `sp_out` equals `sp_in` + 4×`frame_imm` + 4×(number selected).
- R5: In exit mode with a nonzero `jump_reg`, `pc_valid` is high in the done cycle. At that point `pc_out` holds the value of that register after every load has been applied. In exit mode with `jump_reg` = 0, and in every entry operation, `pc_valid` stays low.
- R6: Every memory transfer is one 32-bit word. While `mem_req` is high and `mem_ready` is low, the request keeps its address, direction and write data.
- R7: When the list mask is empty, `done` is high in the cycle right after the start cycle and no memory request is made. With a zero immediate as well, `sp_out` equals `sp_in`.
- R8: `done` is high for exactly one cycle per operation. That cycle follows the last stack-pointer update or load, and `busy` is low in it. `sp_out` holds its value while the block is idle.
- R9: A start pulse that arrives while `busy` is high has no effect: the running operation finishes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| mode | input | 1 | 0 = frame entry, 1 = frame exit |
| list_mask | input | 12 | Bit i selects register 20+i |
| frame_imm | input | 5 | Local frame size in words |
| jump_reg | input | 5 | Exit only: register holding the next PC, 0 for none |
| sp_in | input | 32 | Stack pointer at start |
| reg_addr | output | 5 | Register file index for read or write |
| reg_rdata | input | 32 | Combinational read data for `reg_addr` |
| reg_we | output | 1 | Register write enable |
| reg_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts or completes the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Current or final stack pointer |
| pc_valid | output | 1 | `pc_out` carries a jump target this cycle |
| pc_out | output | 32 | Jump target taken from `jump_reg` |

## Verification
A wrong pending-list bit or a wrong scan direction puts a register at the wrong address, or writes the wrong word into a register. The bench sees this as soon as the operation ends, when it compares every frame word and every restored register with its own model. A fault in the stack-pointer arithmetic shows up on `sp_out` in the cycle after the faulty handshake, where the bound checker compares it with the address just transferred. It is also caught in the final stack-pointer check. A fault in sequencing, such as a late `done`, a request that drops before ready, or a start accepted while busy, shows at once on the handshake signals, or else in the values that remain at the end of the operation.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } seq_state_e;

    localparam logic MODE_ENTRY = 1'b0;
    localparam logic MODE_EXIT  = 1'b1;
endpackage

// File: rtl/frame_seq_agu.sv
module frame_seq_agu #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  step_dn,
    output logic [XLEN-1:0]  step_up,
    output logic [XLEN-1:0]  frame_dn,
    output logic [XLEN-1:0]  frame_up
);
    localparam int SH = $clog2(WORD_BYTES);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] frame_bytes;

    always_comb begin
        frame_bytes = XLEN'(imm) << SH;
        step_dn     = base - STEP;
        step_up     = base + STEP;
        frame_dn    = base - frame_bytes;
        frame_up    = base + frame_bytes;
    end
endmodule

// File: rtl/frame_seq_pick.sv
module frame_seq_pick #(
    parameter int NREG  = 12,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  pend,
    input  logic             from_top,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) lo_idx = IDX_W'(i);
        end
        hi_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (pend[i]) hi_idx = IDX_W'(i);
        end
        any = |pend;
        idx = from_top ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int NREG       = 12,
    parameter int FIRST_REG  = 20,
    parameter int XLEN       = 32,
    parameter int IMM_W      = 5,
    parameter int RIDX_W     = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [NREG-1:0]   list_mask,
    input  logic [IMM_W-1:0]  frame_imm,
    input  logic [RIDX_W-1:0] jump_reg,
    input  logic [XLEN-1:0]   sp_in,
    output logic [RIDX_W-1:0] reg_addr,
    input  logic [XLEN-1:0]   reg_rdata,
    output logic              reg_we,
    output logic [XLEN-1:0]   reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   sp_out,
    output logic              pc_valid,
    output logic [XLEN-1:0]   pc_out
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [RIDX_W-1:0] BASE_IDX = RIDX_W'(FIRST_REG);

    typedef struct packed {
        seq_state_e        st;
        logic [NREG-1:0]   pend;
        logic [IMM_W-1:0]  imm;
        logic [RIDX_W-1:0] jreg;
        logic [XLEN-1:0]   sp;
        logic              done;
        logic              pcv;
        logic [XLEN-1:0]   pc;
    } seq_t;

    localparam seq_t SEQ_RESET = '0;

    seq_t q, d;

    logic [XLEN-1:0]  agu_base;
    logic [IMM_W-1:0] agu_imm;
    logic [XLEN-1:0]  sp_step_dn, sp_step_up, sp_frame_dn, sp_frame_up;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             idle;

    assign idle     = (q.st == ST_IDLE);
    assign agu_base = idle ? sp_in : q.sp;
    assign agu_imm  = idle ? frame_imm : q.imm;

    frame_seq_agu #(
        .XLEN(XLEN), .IMM_W(IMM_W), .WORD_BYTES(WORD_BYTES)
    ) u_agu (
        .base    (agu_base),
        .imm     (agu_imm),
        .step_dn (sp_step_dn),
        .step_up (sp_step_up),
        .frame_dn(sp_frame_dn),
        .frame_up(sp_frame_up)
    );

    frame_seq_pick #(
        .NREG(NREG), .IDX_W(IDX_W)
    ) u_pick (
        .pend    (q.pend),
        .from_top(q.st == ST_POP),
        .any     (pick_any),
        .idx     (pick_idx)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.pcv     = 1'b0;
        reg_addr  = '0;
        reg_we    = 1'b0;
        reg_wdata = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (q.st)
            ST_IDLE: begin
                // The jump register is read here so an empty exit can finish at once.
                reg_addr = jump_reg;
                if (start) begin
                    d.pend = list_mask;
                    d.imm  = frame_imm;
                    d.jreg = jump_reg;
                    if (mode == MODE_ENTRY) begin
                        if (list_mask == '0) begin
                            d.sp   = sp_frame_dn;
                            d.done = 1'b1;
                        end else begin
                            d.sp = sp_in;
                            d.st = ST_PUSH;
                        end
                    end else begin
                        // Exit moves past the local area before any load.
                        d.sp = sp_frame_up;
                        if (list_mask == '0) begin
                            d.done = 1'b1;
                            if (jump_reg != '0) begin
                                d.pcv = 1'b1;
                                d.pc  = reg_rdata;
                            end
                        end else begin
                            d.st = ST_POP;
                        end
                    end
                end
            end
            ST_PUSH: begin
                if (pick_any) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = sp_step_dn;
                    reg_addr  = BASE_IDX + RIDX_W'(pick_idx);
                    mem_wdata = reg_rdata;
                    if (mem_ready) begin
                        d.sp             = sp_step_dn;
                        d.pend[pick_idx] = 1'b0;
                    end
                end else begin
                    d.sp   = sp_frame_dn;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_POP: begin
                if (pick_any) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b0;
                    mem_addr = q.sp;
                    if (mem_ready) begin
                        reg_we           = 1'b1;
                        reg_addr         = BASE_IDX + RIDX_W'(pick_idx);
                        reg_wdata        = mem_rdata;
                        d.sp             = sp_step_up;
                        d.pend[pick_idx] = 1'b0;
                    end
                end else begin
                    reg_addr = q.jreg;
                    if (q.jreg != '0) begin
                        d.pcv = 1'b1;
                        d.pc  = reg_rdata;
                    end
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= d;
    end

    assign busy     = !idle;
    assign done     = q.done;
    assign sp_out   = q.sp;
    assign pc_valid = q.pcv;
    assign pc_out   = q.pc;
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            pc_valid,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            reg_we,
    input logic [XLEN-1:0] sp_out
);
    // R2
    store_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> sp_out == $past(mem_addr));

    // R4
    load_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> sp_out == $past(mem_addr) + XLEN'(WORD_BYTES));

    // R4
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> mem_req && !mem_we && mem_ready);

    // R5
    pc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> done);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(sp_out));
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pc_valid (pc_valid),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .reg_we   (reg_we),
    .sp_out   (sp_out)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        mode;
    logic [11:0] list_mask;
    logic [4:0]  frame_imm;
    logic [4:0]  jump_reg;
    logic [31:0] sp_in;
    logic [4:0]  reg_addr;
    logic [31:0] reg_rdata;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        busy;
    logic        done;
    logic [31:0] sp_out;
    logic        pc_valid;
    logic [31:0] pc_out;

    logic [31:0] rf  [32];
    logic [31:0] mem [256];
    logic        rdy_rand;
    int          n_tests;
    int          n_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_seq u_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .list_mask(list_mask), .frame_imm(frame_imm), .jump_reg(jump_reg),
        .sp_in(sp_in), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
        .done(done), .sp_out(sp_out), .pc_valid(pc_valid), .pc_out(pc_out)
    );

    assign reg_rdata = rf[reg_addr];
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (reg_we) rf[reg_addr] <= reg_wdata;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
    end

    always @(negedge clk) mem_ready <= rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry_sp(input logic [31:0] s, input logic [11:0] m, input logic [4:0] im);
        return s - 32'(4 * $countones(m)) - 32'(4 * im);
    endfunction

    function automatic logic [31:0] exp_exit_sp(input logic [31:0] s, input logic [11:0] m, input logic [4:0] im);
        return s + 32'(4 * im) + 32'(4 * $countones(m));
    endfunction

    task automatic run_op(input bit md, input logic [11:0] msk, input logic [4:0] im,
                          input logic [4:0] jr, input logic [31:0] spv, input bit poke);
        logic [31:0] snap [32];
        logic [31:0] er   [32];
        logic [31:0] s;
        logic [31:0] exp_sp;
        int          k;
        int          cnt;
        for (int i = 20; i < 32; i++) rf[i] = $urandom;
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int i = 0; i < 32; i++) begin snap[i] = rf[i]; er[i] = rf[i]; end
        if (md) begin
            s = spv + 32'(4 * im);
            for (int i = 11; i >= 0; i--) begin
                if (msk[i]) begin er[20 + i] = mem[s[9:2]]; s = s + 32'd4; end
            end
            exp_sp = exp_exit_sp(spv, msk, im);
        end else begin
            exp_sp = exp_entry_sp(spv, msk, im);
        end
        start = 1'b1; mode = md; list_mask = msk; frame_imm = im; jump_reg = jr; sp_in = spv;
        @(negedge clk);
        start = 1'b0;
        if (msk == '0) chk(done === 1'b1, "R7 empty list done next cycle", 32'(done), 32'd1);
        if (poke && msk != '0) begin
            start = 1'b1; mode = ~md; list_mask = ~msk; frame_imm = ~im; sp_in = spv + 32'h40;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (done !== 1'b1 && cnt < 3000) begin @(negedge clk); cnt++; end
        chk(done === 1'b1, "R8 done pulse seen", 32'(done), 32'd1);
        chk(sp_out === exp_sp, md ? "R4 exit final sp" : "R3 entry final sp", sp_out, exp_sp);
        if (md && jr != 5'd0) begin
            chk(pc_valid === 1'b1, "R5 pc_valid on exit jump", 32'(pc_valid), 32'd1);
            chk(pc_out === er[jr], "R5 jump target value", pc_out, er[jr]);
        end else begin
            chk(pc_valid === 1'b0, "R5 no pc without jump", 32'(pc_valid), 32'd0);
        end
        @(negedge clk);
        chk(done === 1'b0, "R8 done lasts one cycle", 32'(done), 32'd0);
        chk(sp_out === exp_sp, "R8 sp holds while idle", sp_out, exp_sp);
        if (poke) chk(busy === 1'b0, "R9 busy start ignored", 32'(busy), 32'd0);
        if (md) begin
            for (int i = 20; i < 32; i++)
                chk(rf[i] === er[i], poke ? "R9 exit regs unaffected" : "R4 restored register", rf[i], er[i]);
        end else begin
            k = 0;
            for (int i = 0; i < 12; i++) begin
                if (msk[i]) begin
                    k++;
                    s = spv - 32'(4 * k);
                    chk(mem[s[9:2]] === snap[20 + i], poke ? "R9 entry frame unaffected" : "R2 saved word", mem[s[9:2]], snap[20 + i]);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_sink;
        n_tests = 0; n_fail = 0;
        seed_sink = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) rf[i] = 32'h1000 + 32'(i);
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; list_mask = '0; frame_imm = '0;
        jump_reg = '0; sp_in = '0; rdy_rand = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy === 1'b0 && done === 1'b0 && pc_valid === 1'b0, "R1 reset control low", {29'd0, busy, done, pc_valid}, 32'd0);
        chk(mem_req === 1'b0 && reg_we === 1'b0, "R1 reset no access", {30'd0, mem_req, reg_we}, 32'd0);
        chk(sp_out === 32'd0, "R1 reset sp", sp_out, 32'd0);

        // R7 empty list, zero immediate keeps sp
        run_op(1'b0, 12'h000, 5'd0, 5'd0, 32'h200, 1'b0);
        // R7 empty list exit with frame and jump through a low register
        run_op(1'b1, 12'h000, 5'd9, 5'd5, 32'h180, 1'b0);
        // R2 R3 full list entry, directed ready
        run_op(1'b0, 12'hFFF, 5'd31, 5'd0, 32'h240, 1'b0);
        // R4 R5 full list exit, jump target is a just-loaded register
        run_op(1'b1, 12'hFFF, 5'd3, 5'd20, 32'h180, 1'b0);
        // end points of the list
        run_op(1'b0, 12'h001, 5'd1, 5'd0, 32'h200, 1'b0);
        run_op(1'b1, 12'h800, 5'd0, 5'd31, 32'h200, 1'b0);
        // R5 exit without jump
        run_op(1'b1, 12'h5A5, 5'd2, 5'd0, 32'h1C0, 1'b0);
        // R6 random ready
        rdy_rand = 1'b1;
        // R9 start while busy
        run_op(1'b0, 12'h3C3, 5'd4, 5'd0, 32'h200, 1'b1);
        run_op(1'b1, 12'hA05, 5'd6, 5'd26, 32'h180, 1'b1);
        for (int t = 0; t < 40; t++) begin
            run_op(1'($urandom_range(0, 1)), 12'($urandom), 5'($urandom), 5'($urandom),
                   32'h180 + 32'(4 * $urandom_range(0, 48)), 1'($urandom_range(0, 3) == 0));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule